// File: doc/BRIEF.md
# Configuration Save/Restore Sequencer

This block moves a wide volatile configuration word into and out of a nonvolatile store. The store is modelled as a byte-organised register array. A test-port instruction decoder sends one-cycle requests to the block. A save copies the live configuration into the store. A restore copies the store back into the live configuration registers through a write port. Each transfer occupies a programmable number of clock cycles. These cycle counts stand in for times that are inversely proportional to the oscillator frequency. A save lasts longer than a restore and also carries a fixed extension. While a transfer runs, the block reports busy and refuses every new programming request.

A transfer requested by the decoder starts only when three conditions hold: the chip is powered up, the PLL is enabled, and the PLL-disable bit inside the configuration word is clear. After reset the block starts an automatic restore without being asked. That restore needs only the power-up condition. It pauses whenever power is down.

Top module: `cfgseq_top`

## Requirements
- R1: After reset is released, `busy` is 1 and an automatic restore runs. With `pwr_on` high it lasts exactly BOOT_CYC cycles. In its last cycle it drives the store contents (NV_INIT after reset) on `cfg_wr_data` with `cfg_wr_en` high.
- R2: The automatic restore ignores `pll_off` and `cfg_in[PLL_BIT]`. Each cycle with `pwr_on` low adds one cycle to its length.
- R3: A `restore_req` accepted while idle makes `busy` 1 from the next cycle, for exactly RESTORE_CYC cycles.
- R4: `cfg_wr_en` is 1 only in the last busy cycle of a restore, with `cfg_wr_data` equal to the store contents. It is never 1 during a save.
- R5: A `save_req` accepted while idle keeps `busy` at 1 for exactly SAVE_CYC + SAVE_EXTRA cycles. It loads `cfg_in`, as sampled in its last cycle, into the store, and a later restore returns that word.
- R6: A save or restore request is dropped, with `busy` staying 0 and the store unchanged, when `pwr_on` is 0, when `pll_off` is 1, or when `cfg_in[PLL_BIT]` (bit 57 by default) is 1.
- R7: Save, restore and read/write requests that arrive while `busy` is 1 are ignored, including in the last busy cycle. The running transfer keeps its length.
- R8: `rdwr_ok` pulses for one cycle, in the cycle after `rdwr_req`, only if the block was idle and no transfer was accepted in that same cycle.
- R9: When `save_req` and `restore_req` arrive together while idle, the restore is performed and the save is discarded.
- R10: `restore_done` is a one-cycle pulse in the first idle cycle after a restore writes. It never follows a save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock derived from the oscillator |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| save_req | input | 1 | One-cycle save request from the decoder |
| restore_req | input | 1 | One-cycle restore request from the decoder |
| rdwr_req | input | 1 | One-cycle request to read or write the live configuration |
| pwr_on | input | 1 | 1 when the chip is not powered down |
| pll_off | input | 1 | 1 when the PLL-enable pin disables the PLL |
| cfg_in | input | CFG_W | Current live configuration word |
| busy | output | 1 | Transfer in progress |
| restore_done | output | 1 | Pulse after a restore has written the live word |
| rdwr_ok | output | 1 | Grant pulse for a read/write request |
| cfg_wr_en | output | 1 | Write strobe to the live configuration registers |
| cfg_wr_data | output | CFG_W | Word written to the live configuration registers |

## Verification
Two things can fall in the same cycle: the completion of a transfer, and a new request from the decoder. The bench raises `restore_req` in the very cycle where it sees `cfg_wr_en`. It passes if the transfer still ends on its count, `busy` stays low afterwards, and no second write appears. A second collision is a save and a restore raised together, and a read/write raised alongside a save. It is judged by the length of `busy`, by whether a write appears, and by whether the grant is withheld.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BOOT    = 2'd1,
        ST_RESTORE = 2'd2,
        ST_SAVE    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/cfgseq_gate.sv
// Decides whether a decoder-issued transfer may start.
module cfgseq_gate (
    input  logic pwr_on,
    input  logic pll_off,
    input  logic pll_cfg_bit,
    output logic xfer_ok
);
    always_comb begin
        xfer_ok = pwr_on && !pll_off && !pll_cfg_bit;
    end
endmodule

// File: rtl/cfgseq_timer.sv
// Down-counter: loads a length, counts to zero, holds there.
module cfgseq_timer #(
    parameter int unsigned    CW      = 8,
    parameter logic [CW-1:0]  RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          at_zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/cfgseq_nvarray.sv
// Nonvolatile store model: byte-wide register array, whole-word write.
module cfgseq_nvarray #(
    parameter int unsigned         CFG_W   = 96,
    parameter logic [CFG_W-1:0]    NV_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata
);
    localparam int unsigned NBYTES = CFG_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [7:0] cell_d, cell_q;

        always_comb begin
            cell_d = we ? wdata[8*b +: 8] : cell_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= NV_INIT[8*b +: 8];
            end else begin
                cell_q <= cell_d;
            end
        end

        assign rdata[8*b +: 8] = cell_q;
    end
endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top #(
    parameter int unsigned      CFG_W      = 96,
    parameter int unsigned      PLL_BIT    = 57,
    parameter int unsigned      BOOT_CYC   = 3000,
    parameter int unsigned      RESTORE_CYC = 120,
    parameter int unsigned      SAVE_CYC   = 300,
    parameter int unsigned      SAVE_EXTRA = 520,
    parameter logic [CFG_W-1:0] NV_INIT    = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_req,
    input  logic             restore_req,
    input  logic             rdwr_req,
    input  logic             pwr_on,
    input  logic             pll_off,
    input  logic [CFG_W-1:0] cfg_in,
    output logic             busy,
    output logic             restore_done,
    output logic             rdwr_ok,
    output logic             cfg_wr_en,
    output logic [CFG_W-1:0] cfg_wr_data
);
    import cfgseq_pkg::*;

    localparam int unsigned SAVE_TOT = SAVE_CYC + SAVE_EXTRA;
    localparam int unsigned MAX_A    = (BOOT_CYC > RESTORE_CYC) ? BOOT_CYC : RESTORE_CYC;
    localparam int unsigned MAX_LEN  = (MAX_A > SAVE_TOT) ? MAX_A : SAVE_TOT;
    localparam int unsigned CW       = $clog2(MAX_LEN + 1);
    localparam logic [CW-1:0] BOOT_LD = CW'(BOOT_CYC - 1);
    localparam logic [CW-1:0] REST_LD = CW'(RESTORE_CYC - 1);
    localparam logic [CW-1:0] SAVE_LD = CW'(SAVE_TOT - 1);

    typedef struct packed {
        seq_state_e st;
        logic       done;
        logic       grant;
    } seq_regs_t;

    seq_regs_t        regs_d, regs_q;
    logic             xfer_ok;
    logic             tmr_load, tmr_run, tmr_zero;
    logic [CW-1:0]    tmr_val;
    logic             nv_we, wr_now;
    logic [CFG_W-1:0] nv_rdata;

    cfgseq_gate u_gate (
        .pwr_on      (pwr_on),
        .pll_off     (pll_off),
        .pll_cfg_bit (cfg_in[PLL_BIT]),
        .xfer_ok     (xfer_ok)
    );

    cfgseq_timer #(.CW(CW), .RST_VAL(BOOT_LD)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .at_zero  (tmr_zero)
    );

    cfgseq_nvarray #(.CFG_W(CFG_W), .NV_INIT(NV_INIT)) u_nv (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (nv_we),
        .wdata (cfg_in),
        .rdata (nv_rdata)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.done  = 1'b0;
        regs_d.grant = 1'b0;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        tmr_run      = 1'b0;
        nv_we        = 1'b0;
        wr_now       = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (restore_req && xfer_ok) begin
                    regs_d.st = ST_RESTORE;
                    tmr_load  = 1'b1;
                    tmr_val   = REST_LD;
                end else if (save_req && xfer_ok) begin
                    regs_d.st = ST_SAVE;
                    tmr_load  = 1'b1;
                    tmr_val   = SAVE_LD;
                end else if (rdwr_req) begin
                    regs_d.grant = 1'b1;
                end
            end
            ST_BOOT: begin
                tmr_run = pwr_on;
                if (pwr_on && tmr_zero) begin
                    wr_now      = 1'b1;
                    regs_d.done = 1'b1;
                    regs_d.st   = ST_IDLE;
                end
            end
            ST_RESTORE: begin
                tmr_run = 1'b1;
                if (tmr_zero) begin
                    wr_now      = 1'b1;
                    regs_d.done = 1'b1;
                    regs_d.st   = ST_IDLE;
                end
            end
            ST_SAVE: begin
                tmr_run = 1'b1;
                if (tmr_zero) begin
                    nv_we     = 1'b1;
                    regs_d.st = ST_IDLE;
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_BOOT, done: 1'b0, grant: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign busy         = (regs_q.st != ST_IDLE);
    assign restore_done = regs_q.done;
    assign rdwr_ok      = regs_q.grant;
    assign cfg_wr_en    = wr_now;
    assign cfg_wr_data  = nv_rdata;
endmodule

// File: rtl/cfgseq_checker.sv
module cfgseq_checker (
    input logic clk,
    input logic rst_n,
    input logic save_req,
    input logic restore_req,
    input logic pwr_on,
    input logic busy,
    input logic restore_done,
    input logic rdwr_ok,
    input logic cfg_wr_en
);
    // R3: busy only starts in answer to a request
    a_r3_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(save_req || restore_req));

    // R4: the write happens inside a transfer, and that transfer then ends
    a_r4_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |-> busy);
    a_r4_write_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> !busy);

    // R6: while idle and powered down, no transfer may begin
    a_r6_no_start_powered_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !pwr_on) |=> !busy);

    // R8: grants are given only after an idle cycle
    a_r8_grant_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rdwr_ok |-> !$past(busy));

    // R10: the done pulse follows a write and lasts one cycle
    a_r10_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        restore_done |-> $past(cfg_wr_en));
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        restore_done |=> !restore_done);
endmodule

bind cfgseq_top cfgseq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .save_req     (save_req),
    .restore_req  (restore_req),
    .pwr_on       (pwr_on),
    .busy         (busy),
    .restore_done (restore_done),
    .rdwr_ok      (rdwr_ok),
    .cfg_wr_en    (cfg_wr_en)
);

// File: tb/cfgseq_top_test.sv
`timescale 1ns/1ps
module cfgseq_top_test;
    localparam int W      = 96;
    localparam int PB     = 57;
    localparam int BOOT   = 20;
    localparam int REST   = 6;
    localparam int SAVE   = 10;
    localparam int EXTRA  = 5;
    localparam logic [W-1:0] INIT = 96'hA5A5_0F0F_1234_0000_C3C3_7E7E;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         save_req = 1'b0, restore_req = 1'b0, rdwr_req = 1'b0;
    logic         pwr_on = 1'b1, pll_off = 1'b0;
    logic [W-1:0] cfg_in = '0;
    logic         busy, restore_done, rdwr_ok, cfg_wr_en;
    logic [W-1:0] cfg_wr_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cfgseq_top #(
        .CFG_W(W), .PLL_BIT(PB), .BOOT_CYC(BOOT), .RESTORE_CYC(REST),
        .SAVE_CYC(SAVE), .SAVE_EXTRA(EXTRA), .NV_INIT(INIT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
        .rdwr_req(rdwr_req), .pwr_on(pwr_on), .pll_off(pll_off), .cfg_in(cfg_in),
        .busy(busy), .restore_done(restore_done), .rdwr_ok(rdwr_ok),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] clean(input logic [W-1:0] v);
        return v & ~(96'd1 << PB);
    endfunction

    // Measure one transfer: pulse the requests, then count busy cycles.
    task automatic run_req(input logic s, input logic r, input logic w,
                           output int n, output int wr_at, output logic [W-1:0] wdata,
                           output logic done_after, output logic ok_after);
        @(negedge clk);
        save_req = s; restore_req = r; rdwr_req = w;
        @(negedge clk);
        save_req = 1'b0; restore_req = 1'b0; rdwr_req = 1'b0;
        ok_after = rdwr_ok;
        n = 0; wr_at = -1; wdata = '0;
        while (busy && n < 1000) begin
            n++;
            if (cfg_wr_en) begin wr_at = n; wdata = cfg_wr_data; end
            @(negedge clk);
        end
        done_after = restore_done;
    endtask

    task automatic t_boot(input logic pause);
        int n, wr_at;
        logic [W-1:0] wd;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", W'(busy), W'(1));
        chk("R1 no write in reset", W'(cfg_wr_en), W'(0));
        chk("R10 no done in reset", W'(restore_done), W'(0));
        chk("R8 no grant in reset", W'(rdwr_ok), W'(0));
        rst_n = 1'b1;
        n = 0; wr_at = -1; wd = '0;
        while (busy && n < 1000) begin
            n++;
            if (cfg_wr_en) begin wr_at = n; wd = cfg_wr_data; end
            if (pause && n == 5) begin
                pwr_on = 1'b0;
                repeat (5) @(negedge clk);
                pwr_on = 1'b1;
            end
            @(negedge clk);
        end
        if (pause) begin
            // R2: five paused cycles are not counted in n
            chk("R2 boot length with pause", W'(n), W'(BOOT));
            chk("R2 boot writes despite pll_off/bit57", wd, INIT);
        end else begin
            chk("R1 boot length", W'(n), W'(BOOT));
            chk("R1 boot write cycle", W'(wr_at), W'(BOOT));
            chk("R1 boot data", wd, INIT);
        end
        chk("R10 done after boot", W'(restore_done), W'(1));
    endtask

    task automatic t_save_restore;
        int n, wr_at;
        logic [W-1:0] wd;
        logic dn, ok;
        logic [W-1:0] pat = clean(96'h0123_4567_89AB_CDEF_0011_2233);
        cfg_in = pat;
        run_req(1'b1, 1'b0, 1'b0, n, wr_at, wd, dn, ok);
        chk("R5 save length", W'(n), W'(SAVE + EXTRA));
        chk("R4 no write during save", W'(wr_at), W'(-1));
        chk("R10 no done after save", W'(dn), W'(0));
        cfg_in = clean(96'hFFFF_0000_FFFF_0000_FFFF_0000);
        run_req(1'b0, 1'b1, 1'b0, n, wr_at, wd, dn, ok);
        chk("R3 restore length", W'(n), W'(REST));
        chk("R4 write in last cycle", W'(wr_at), W'(REST));
        chk("R5 restore returns saved word", wd, pat);
        chk("R10 done after restore", W'(dn), W'(1));
    endtask

    task automatic t_gating;
        int n, wr_at;
        logic [W-1:0] wd;
        logic dn, ok;
        logic [W-1:0] keep = clean(96'h0123_4567_89AB_CDEF_0011_2233);
        cfg_in = clean(96'h5555_AAAA_5555_AAAA_5555_AAAA);
        pwr_on = 1'b0;
        run_req(1'b0, 1'b1, 1'b0, n, wr_at, wd, dn, ok);
        chk("R6 restore dropped when powered down", W'(n), W'(0));
        pwr_on = 1'b1; pll_off = 1'b1;
        run_req(1'b1, 1'b0, 1'b0, n, wr_at, wd, dn, ok);
        chk("R6 save dropped when PLL off", W'(n), W'(0));
        pll_off = 1'b0;
        cfg_in = cfg_in | (96'd1 << PB);
        run_req(1'b1, 1'b0, 1'b0, n, wr_at, wd, dn, ok);
        chk("R6 save dropped when bit set", W'(n), W'(0));
        cfg_in = clean(cfg_in);
        run_req(1'b0, 1'b1, 1'b0, n, wr_at, wd, dn, ok);
        chk("R6 store unchanged by dropped saves", wd, keep);
    endtask

    task automatic t_collide;
        int n, wr_at, writes;
        logic [W-1:0] wd;
        logic dn, ok;
        logic [W-1:0] keep = clean(96'h0123_4567_89AB_CDEF_0011_2233);
        // R7: requests mid-transfer and in the final cycle
        @(negedge clk);
        restore_req = 1'b1;
        @(negedge clk);
        restore_req = 1'b0;
        n = 0; writes = 0;
        cfg_in = clean(96'h1111_2222_3333_4444_5555_6666);
        while (busy && n < 1000) begin
            n++;
            save_req = 1'b0; restore_req = 1'b0; rdwr_req = 1'b0;
            if (n == 2) begin save_req = 1'b1; rdwr_req = 1'b1; end
            if (cfg_wr_en) begin writes++; restore_req = 1'b1; end
            @(negedge clk);
            if (n == 2) chk("R7 grant refused while busy", W'(rdwr_ok), W'(0));
        end
        save_req = 1'b0; restore_req = 1'b0; rdwr_req = 1'b0;
        chk("R7 length unchanged", W'(n), W'(REST));
        repeat (2) @(negedge clk);
        chk("R7 final-cycle request ignored", W'(busy), W'(0));
        chk("R7 single write", W'(writes), W'(1));
        cfg_in = keep;
        run_req(1'b0, 1'b1, 1'b0, n, wr_at, wd, dn, ok);
        chk("R7 rejected save left store", wd, keep);
        // R9: both requests together
        run_req(1'b1, 1'b1, 1'b0, n, wr_at, wd, dn, ok);
        chk("R9 restore wins length", W'(n), W'(REST));
        chk("R9 restore wins write", W'(wr_at), W'(REST));
        // R8: grants
        run_req(1'b0, 1'b0, 1'b1, n, wr_at, wd, dn, ok);
        chk("R8 grant when idle", W'(ok), W'(1));
        @(negedge clk);
        chk("R8 grant is one pulse", W'(rdwr_ok), W'(0));
        run_req(1'b1, 1'b0, 1'b1, n, wr_at, wd, dn, ok);
        chk("R8 no grant beside accepted save", W'(ok), W'(0));
        chk("R8 save still runs", W'(n), W'(SAVE + EXTRA));
    endtask

    initial begin
        t_boot(1'b0);
        t_save_restore();
        t_gating();
        t_collide();
        pll_off = 1'b1;
        cfg_in = cfg_in | (96'd1 << PB);
        t_boot(1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule